// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a set of interrupt input pins to interrupt messages. Each pin owns a 64-bit redirection entry. The entry sets the vector, the delivery mode, the destination mode, the destination ID, the input polarity, the trigger mode and a mask bit. Software reaches every register indirectly. It first writes an index into a select register at byte offset 0x00. It then reads or writes a 32-bit data window at byte offset 0x10. A bus read returns its data one cycle after the access.

An unmasked pin that asserts produces one message on a valid/ready output. The message carries the entry's vector, delivery mode, destination mode and destination ID. An edge-triggered pin raises a request on each inactive-to-active transition. A level-triggered pin raises a request while it is active and its in-service flag is clear. That flag is set when the message is accepted. It is cleared by an end-of-interrupt input whose vector equals the entry's vector. When several requests are pending, the lowest pin number is sent first.

Top module: `irq_redirector`

## Requirements
- R1: After reset, `msg_valid` is 0, the ID register reads 0, and every entry reads 0x00010000 in its low word (only the mask, bit 16, set) and 0 in its high word.
- R2: A write at byte offset 0x00 loads the 8-bit index, and a read there returns it in bits 7:0. Offsets 0x04, 0x08 and 0x0C read 0 and ignore writes. `bus_rdata` is valid the cycle after the read access.
- R3: Index 0x00 holds an 8-bit ID in bits 31:24; all other bits read 0. Index 0x01 is read-only and reads {8'h00, NUM_PINS-1, 8'h00, VERSION}.
- R4: Entry n is at index 0x10+2n (low word) and 0x11+2n (high word). Low word: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13 (1 = active low), in-service flag 14, trigger 15 (1 = level), mask 16. High word: destination 31:24. Unused bits read 0.
- R5: Delivery status (bit 12) and in-service (bit 14) ignore writes.
- R6: Any index that is not implemented reads 0xFFFFFFFF and ignores writes.
- R7: An unmasked edge-mode pin sends exactly one message per inactive-to-active transition of its polarity-adjusted input. An input that stays active sends nothing further.
- R8: A request that arrives while `msg_ready` is low is kept. A presented message holds all of its fields stable until it is accepted.
- R9: An unmasked level-mode pin sends a message while it is active and its in-service flag is clear, and acceptance sets the flag. While the flag is set, the pin sends nothing. An end-of-interrupt with a matching vector clears the flag; one with any other vector has no effect.
- R10: A masked pin neither sends messages nor holds a pending request. Unmasking an active level-mode pin sends a message.
- R11: When several pins are pending, the lowest pin number is sent first.
- R12: Delivery status reads 1 while a request is pending or in flight, and 0 once it is accepted.
- R13: Message fields carry the entry's vector, delivery mode (000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT, 111 external), destination mode and destination ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset (0x00 select, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_PINS | Interrupt input pins, synchronous to clk |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode |
| msg_dmode | output | 1 | Destination mode, 1 = logical |
| msg_dest | output | 8 | Destination ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being ended |

## Verification
Some properties are checked on every cycle. A stalled message must keep its fields stable. A newly presented message must come from the lowest eligible pin and never from a masked one. A level pin must never be pending while its in-service flag is set. A level acceptance must set that flag. The bench scenarios cover the rest: register layout and read-only bits, the number of messages per edge, the end-of-interrupt vector match, and unmask-while-active delivery. These can only be judged across a whole sequence against the expected message list.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                 dmode: 1'b0, dlv: 3'b000, vec: 8'h00};

  localparam logic [4:0] OFS_SEL = 5'h00;
  localparam logic [4:0] OFS_WIN = 5'h10;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_TBL = 8'h10;

endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_raw,
  input  logic       cfg_pol,
  input  logic       cfg_trig,
  input  logic       cfg_mask,
  input  logic [7:0] cfg_vec,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vec,
  input  logic       accept,
  output logic       pend,
  output logic       rirr
);

  logic act, act_q;
  assign act = irq_raw ^ cfg_pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      pend  <= 1'b0;
      rirr  <= 1'b0;
    end else begin
      act_q <= act;
      // pending request
      if (cfg_mask)
        pend <= 1'b0;
      else if (cfg_trig)
        pend <= act & ~rirr & ~accept;
      else
        pend <= (pend & ~accept) | (act & ~act_q);
      // in-service flag, level mode only
      if (!cfg_trig)
        rirr <= 1'b0;
      else if (accept)
        rirr <= 1'b1;
      else if (eoi_valid && eoi_vec == cfg_vec)
        rirr <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 24,
  parameter int PW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [PW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = PW'(i);
  end

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dlv,
  output logic                msg_dmode,
  output logic [7:0]          msg_dest,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector
);

  localparam int         PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [7:0] TBL_END  = 8'(IDX_TBL + 2 * NUM_PINS);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [7:0]          sel_q, id_q;
  rte_t                tbl [NUM_PINS];
  logic [NUM_PINS-1:0] pend, rirr, acc, mask_v, trig_v, elig;
  logic [PIN_W-1:0]    cur_pin, pick, rd_pin;
  logic                found, in_tbl, win_wr;
  logic [7:0]          tbl_off;
  logic [31:0]         win_rd;
  rte_t                rd_e;

  assign win_wr  = bus_en & bus_we & (bus_addr == OFS_WIN);
  assign in_tbl  = (sel_q >= IDX_TBL) && (sel_q < TBL_END);
  assign tbl_off = sel_q - IDX_TBL;
  assign rd_pin  = PIN_W'(tbl_off >> 1);

  // select and ID registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 8'h00;
      id_q  <= 8'h00;
    end else if (bus_en && bus_we) begin
      if (bus_addr == OFS_SEL) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == IDX_ID) id_q <= bus_wdata[31:24];
    end
  end

  // redirection table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) tbl[i] <= RTE_RESET;
    end else if (win_wr && in_tbl) begin
      if (sel_q[0]) begin
        tbl[rd_pin].dest <= bus_wdata[31:24];
      end else begin
        tbl[rd_pin].vec   <= bus_wdata[7:0];
        tbl[rd_pin].dlv   <= bus_wdata[10:8];
        tbl[rd_pin].dmode <= bus_wdata[11];
        tbl[rd_pin].pol   <= bus_wdata[13];
        tbl[rd_pin].trig  <= bus_wdata[15];
        tbl[rd_pin].mask  <= bus_wdata[16];
      end
    end
  end

  logic wire_unused;
  assign wire_unused = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

  // per-pin request logic
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign mask_v[i] = tbl[i].mask;
      assign trig_v[i] = tbl[i].trig;
      assign acc[i]    = msg_valid & msg_ready & (cur_pin == PIN_W'(i));
      irq_pin_ctl i_pin (
        .clk       (clk),
        .rst       (rst),
        .irq_raw   (irq_in[i]),
        .cfg_pol   (tbl[i].pol),
        .cfg_trig  (tbl[i].trig),
        .cfg_mask  (tbl[i].mask),
        .cfg_vec   (tbl[i].vec),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vector),
        .accept    (acc[i]),
        .pend      (pend[i]),
        .rirr      (rirr[i])
      );
    end
  endgenerate

  assign elig = pend & ~mask_v;

  irq_prio_pick #(.N(NUM_PINS), .PW(PIN_W)) i_pick (
    .req (elig),
    .any (found),
    .idx (pick)
  );

  // message output register
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      cur_pin    <= '0;
      msg_vector <= 8'h00;
      msg_dlv    <= 3'b000;
      msg_dmode  <= 1'b0;
      msg_dest   <= 8'h00;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid  <= 1'b1;
      cur_pin    <= pick;
      msg_vector <= tbl[pick].vec;
      msg_dlv    <= tbl[pick].dlv;
      msg_dmode  <= tbl[pick].dmode;
      msg_dest   <= tbl[pick].dest;
    end
  end

  // window read mux
  assign rd_e = tbl[rd_pin];
  always_comb begin
    win_rd = 32'hFFFF_FFFF;
    if (sel_q == IDX_ID)
      win_rd = {id_q, 24'h0};
    else if (sel_q == IDX_VER)
      win_rd = VER_WORD;
    else if (in_tbl)
      win_rd = sel_q[0] ? {rd_e.dest, 24'h0}
                        : {15'h0, rd_e.mask, rd_e.trig, rirr[rd_pin], rd_e.pol,
                           pend[rd_pin], rd_e.dmode, rd_e.dlv, rd_e.vec};
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= 32'h0;
    else if (bus_en && !bus_we)
      case (bus_addr)
        OFS_SEL: bus_rdata <= {24'h0, sel_q};
        OFS_WIN: bus_rdata <= win_rd;
        default: bus_rdata <= 32'h0;
      endcase
  end

endmodule

// File: rtl/irq_redirector_chk.sv
module irq_redirector_chk #(
  parameter int N  = 24,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [7:0]    msg_vector,
  input logic [2:0]    msg_dlv,
  input logic          msg_dmode,
  input logic [7:0]    msg_dest,
  input logic [PW-1:0] cur_pin,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask_v,
  input logic [N-1:0]  trig_v,
  input logic [N-1:0]  rirr
);

  logic [N-1:0] elig_q, low_mask;

  always_ff @(posedge clk) begin
    if (rst) elig_q <= '0;
    else     elig_q <= pend & ~mask_v;
  end

  assign low_mask = (N'(1) << cur_pin) - N'(1);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !msg_valid);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
    $stable(msg_dlv) && $stable(msg_dmode) && $stable(msg_dest));

  // R10 and R11: a new message comes from the lowest unmasked pending pin
  a_r11_lowest_first: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> elig_q[cur_pin] && ((elig_q & low_mask) == '0));

  a_r9_no_pend_in_service: assert property (@(posedge clk) disable iff (rst)
    (pend & rirr & trig_v) == '0);

  a_r9_accept_sets_flag: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready && trig_v[cur_pin] |=> rirr[$past(cur_pin)]);

endmodule

bind irq_redirector irq_redirector_chk #(.N(NUM_PINS), .PW(PIN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_dlv    (msg_dlv),
  .msg_dmode  (msg_dmode),
  .msg_dest   (msg_dest),
  .cur_pin    (cur_pin),
  .pend       (pend),
  .mask_v     (mask_v),
  .trig_v     (trig_v),
  .rirr       (rirr)
);

// File: tb/test_irq_redirector.sv
`timescale 1ns/1ps
module test_irq_redirector;

  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dlv;
  logic        msg_dmode;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [19:0] sb_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  irq_redirector #(.NUM_PINS(NP), .VERSION(8'h20)) i_irq_redirector (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv(msg_dlv), .msg_dmode(msg_dmode), .msg_dest(msg_dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_wr(5'h00, {24'h0, idx});
    bus_wr(5'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_wr(5'h00, {24'h0, idx});
    bus_rd(5'h10, d);
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] v, input logic [2:0] dl,
                            input logic dm, input logic [7:0] ds);
    sb_q.push_back({v, dl, dm, ds});
    tag_q.push_back(tag);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(posedge clk); #1;
    eoi_valid = 1'b1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 1'b0;
  endtask

  // monitor: compare every accepted message against the scoreboard
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7/R9/R10 unexpected message actual=%h expected=none",
                 {msg_vector, msg_dlv, msg_dmode, msg_dest});
      end else begin
        logic [19:0] e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {12'h0, msg_vector, msg_dlv, msg_dmode, msg_dest}, {12'h0, e});
      end
    end
  end

  initial begin
    logic [31:0] d;
    tick(4);
    rst = 1'b0;
    tick(2);

    // R1 reset state
    chk("R1 msg_valid", {31'h0, msg_valid}, 32'h0);
    reg_rd(8'h00, d); chk("R1 id", d, 32'h0);
    for (int i = 0; i < NP; i++) begin
      reg_rd(8'(8'h10 + 2 * i), d); chk("R1 entry lo", d, 32'h0001_0000);
      reg_rd(8'(8'h11 + 2 * i), d); chk("R1 entry hi", d, 32'h0);
    end

    // R2 select and reserved offsets
    bus_wr(5'h00, 32'h13);
    bus_rd(5'h00, d); chk("R2 select readback", d, 32'h13);
    bus_wr(5'h04, 32'hDEAD_BEEF);
    bus_rd(5'h04, d); chk("R2 reserved read", d, 32'h0);
    bus_rd(5'h00, d); chk("R2 select untouched", d, 32'h13);

    // R3 ID and version
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); chk("R3 id", d, 32'hFF00_0000);
    reg_wr(8'h01, 32'hFFFF_FFFF);
    reg_rd(8'h01, d); chk("R3 version", d, 32'h0007_0020);

    // R6 unimplemented indices
    reg_rd(8'h02, d); chk("R6 idx 0x02", d, 32'hFFFF_FFFF);
    reg_wr(8'h20, 32'h0000_00AA);
    reg_rd(8'h20, d); chk("R6 idx past table", d, 32'hFFFF_FFFF);
    reg_rd(8'h1E, d); chk("R6 last entry untouched", d, 32'h0001_0000);

    // R4 and R5 layout and read-only bits
    reg_wr(8'h16, 32'hFFFF_FFFF);
    reg_rd(8'h16, d); chk("R4 R5 entry3 lo", d, 32'h0001_AFFF);
    reg_wr(8'h17, 32'hFFFF_FFFF);
    reg_rd(8'h17, d); chk("R4 entry3 hi", d, 32'hFF00_0000);
    reg_wr(8'h16, 32'h0001_0000);

    // R7 and R13 edge pin 0
    reg_wr(8'h11, 32'h0500_0000);
    reg_wr(8'h10, 32'h0000_0031);
    expect_msg("R7 R13 edge pin0", 8'h31, 3'b000, 1'b0, 8'h05);
    irq_in[0] = 1'b1; tick(8);
    irq_in[0] = 1'b0; tick(4);
    chk("R7 single message", sb_q.size(), 0);

    // R8 and R12 stall on pin 1, NMI, logical
    reg_wr(8'h13, 32'hA000_0000);
    reg_wr(8'h12, 32'h0000_0C32);
    msg_ready = 1'b0;
    irq_in[1] = 1'b1; tick(2);
    irq_in[1] = 1'b0; tick(8);
    chk("R8 valid held", {31'h0, msg_valid}, 32'h1);
    chk("R8 vector held", {24'h0, msg_vector}, 32'h32);
    reg_rd(8'h12, d); chk("R12 status pending", d, 32'h0000_1C32);
    expect_msg("R8 R13 stalled pin1", 8'h32, 3'b100, 1'b1, 8'hA0);
    msg_ready = 1'b1; tick(4);
    reg_rd(8'h12, d); chk("R12 status after accept", d, 32'h0000_0C32);

    // R11 priority: pins 2 and 5 together
    reg_wr(8'h15, 32'h0200_0000);
    reg_wr(8'h14, 32'h0000_0033);
    reg_wr(8'h1B, 32'h0300_0000);
    reg_wr(8'h1A, 32'h0000_0136);
    msg_ready = 1'b0;
    irq_in[2] = 1'b1; irq_in[5] = 1'b1; tick(6);
    expect_msg("R11 pin2 first", 8'h33, 3'b000, 1'b0, 8'h02);
    expect_msg("R11 pin5 second", 8'h36, 3'b001, 1'b0, 8'h03);
    msg_ready = 1'b1; tick(8);
    irq_in[2] = 1'b0; irq_in[5] = 1'b0; tick(2);
    chk("R11 both delivered", sb_q.size(), 0);

    // R9 level, active low, pin 6
    irq_in[6] = 1'b1;
    reg_wr(8'h1C, 32'h0000_A040);
    tick(4);
    chk("R9 inactive quiet", sb_q.size(), 0);
    expect_msg("R9 level first", 8'h40, 3'b000, 1'b0, 8'h00);
    irq_in[6] = 1'b0; tick(12);
    reg_rd(8'h1C, d); chk("R9 in-service set", d, 32'h0000_E040);
    eoi(8'h41); tick(6);
    reg_rd(8'h1C, d); chk("R9 other vector no effect", d, 32'h0000_E040);
    expect_msg("R9 redelivery after eoi", 8'h40, 3'b000, 1'b0, 8'h00);
    eoi(8'h40); tick(8);
    chk("R9 redelivered", sb_q.size(), 0);
    irq_in[6] = 1'b1; tick(2);
    eoi(8'h40); tick(6);
    reg_rd(8'h1C, d); chk("R9 flag cleared", d, 32'h0000_A040);

    // R10 mask on level pin 7
    irq_in[7] = 1'b1;
    reg_wr(8'h1E, 32'h0001_8050);
    tick(10);
    reg_rd(8'h1E, d); chk("R10 masked no pending", d, 32'h0001_8050);
    chk("R10 masked no message", sb_q.size(), 0);
    expect_msg("R10 unmask delivers", 8'h50, 3'b000, 1'b0, 8'h00);
    reg_wr(8'h1E, 32'h0000_8050);
    tick(6);
    reg_wr(8'h1E, 32'h0001_8050);
    eoi(8'h50); tick(8);
    irq_in[7] = 1'b0;
    tick(20);
    chk("R10 scoreboard drained", sb_q.size(), 0);

    finish_run();
  end

endmodule